// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block sits beside a small microcontroller core and controls when that core runs. Software first retires an arming instruction. If the next retired instruction is one of two sleep instructions, the block halts the core and enters one of two sleep depths. A light sleep keeps the sub-clock running so that a timer can still expire. A deep sleep, used for RAM retention, stops every oscillator.

A wakeup event starts a stabilization wait. The events accepted depend on the depth: a key press or a timer underflow in light sleep, and only a key press in deep sleep. The wait counts ticks of the selected source clock, and the core is released once the count is exhausted.

The block keeps two flags that software reads at program start. A sticky sleep flag separates a cold start from a warm start. A timer flag separates a timer-driven return from a key-driven one. The clock-source choice and the division ratio are held in registers that keep their values through sleep.

Top module: `pdw_sequencer`

## Requirements
- R1: After reset, `run_en`=1, `pd_flag`=0, `t3_flag`=0 and `sel_q`=2'b00 (main clock). `osc_main_en` and `osc_sub_en` are 1 and `osc_ring_en` is 0.
- R2: Instructions are retired when `instr_valid`=1, with `instr_op` encoded as 0=other, 1=arm, 2=light sleep, 3=deep sleep. A light-sleep op retired immediately after an arm op clears `run_en` at that edge. Cycles with `instr_valid`=0 do not count as instructions. In light sleep `osc_main_en`=0, `osc_ring_en`=0 and `osc_sub_en`=1.
- R3: A deep-sleep op retired immediately after an arm op clears `run_en` at that edge and drives all three oscillator enables to 0.
- R4: Any other retired op between the arm op and the sleep op cancels the arming. A sleep op that is not armed has no effect: `run_en` stays 1.
- R5: In light sleep, `key_wake`=1 or `timer_wake`=1 starts the stabilization wait.
- R6: In deep sleep, `timer_wake` is ignored and the block stays asleep. Only `key_wake` starts the wait.
- R7: The wait length N is counted in ticks of the selected source: `tick_main` for `sel_q`=0, `tick_sub` for `sel_q`=1, and `tick_ring` for `sel_q`=2 or 3. N is 1376 when the ring source wakes from light sleep, and `div_q`×171 in every other case. `run_en` rises on the edge after the count reaches zero, which is N+1 edges after the wake edge when a tick arrives every cycle. Edges without a tick add one cycle each.
- R8: Wakeup events that arrive during the wait are ignored: the wait is neither restarted nor shortened.
- R9: `pd_flag` becomes 1 on entry to either sleep depth and returns to 0 only through reset.
- R10: At each wakeup, `t3_flag` becomes 1 if the wake came from a timer underflow without a key press in the same cycle, and 0 otherwise.
- R11: While `run_en`=1, `sel_we` loads `sel_in` and `div_in` into `sel_q` and the held ratio. Outside run, `sel_we` is ignored. The selection is kept through sleep and wakeup. During the wait, the enable of the selected oscillator is 1.
- R12: `osc_sub_en` is 1 in every state except deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction retired this cycle |
| instr_op | input | 2 | Retired op class: 0 other, 1 arm, 2 light sleep, 3 deep sleep |
| key_wake | input | 1 | Key-on wakeup event |
| timer_wake | input | 1 | Timer underflow event |
| sel_we | input | 1 | Load the clock selection and ratio |
| sel_in | input | 2 | Source select: 0 main, 1 sub, 2 or 3 ring |
| div_in | input | DIV_W | System clock division ratio |
| tick_main | input | 1 | One tick of the main oscillator |
| tick_sub | input | 1 | One tick of the sub oscillator |
| tick_ring | input | 1 | One tick of the ring oscillator |
| run_en | output | 1 | Core may execute |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_sub_en | output | 1 | Sub oscillator enable |
| osc_ring_en | output | 1 | Ring oscillator enable |
| pd_flag | output | 1 | Sticky power-down flag |
| t3_flag | output | 1 | Last wakeup came from a timer underflow |
| sel_q | output | 2 | Held clock-source selection |

## Verification
A stale arming bit shows up within one cycle: `run_en` drops after an unarmed or interrupted sleep op. A wrong wait length, a wrong tick source or a reload during the wait moves the rising edge of `run_en` by a fixed number of cycles, and that number is predicted for every source, depth and ratio. A wrong flag or a lost selection appears at the first sample after wakeup, as a wrong value on `t3_flag`, `pd_flag` or `sel_q`. A wrong oscillator gating appears on the enable outputs one cycle after the sleep op.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_ARM   = 2'd1,
    OP_LIGHT = 2'd2,
    OP_DEEP  = 2'd3
  } op_t;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_RING = 2'd2
  } src_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIGHT = 2'd1,
    ST_DEEP  = 2'd2,
    ST_WAIT  = 2'd3
  } pstate_t;

  // Selector codes 2 and 3 both choose the ring source.
  function automatic src_t decode_src(input logic [1:0] code);
    if (code == 2'd0) return SRC_MAIN;
    else if (code == 2'd1) return SRC_SUB;
    else return SRC_RING;
  endfunction

  // Stabilization length in ticks of the selected source.
  function automatic int unsigned wait_len(input src_t src, input logic from_light,
                                           input int unsigned ratio,
                                           input int unsigned ring_wait,
                                           input int unsigned mult);
    if (src == SRC_RING && from_light) return ring_wait;
    else return ratio * mult;
  endfunction

endpackage

// File: rtl/pdw_entry_decode.sv
module pdw_entry_decode
  import pdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       instr_valid,
  input  logic [1:0] instr_op,
  output logic       enter_light,
  output logic       enter_deep
);

  logic armed_q;
  op_t  op;

  assign op = op_t'(instr_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed_q <= 1'b0;
    else if (!run)        armed_q <= 1'b0;
    else if (instr_valid) armed_q <= (op == OP_ARM);
  end

  assign enter_light = run && instr_valid && armed_q && (op == OP_LIGHT);
  assign enter_deep  = run && instr_valid && armed_q && (op == OP_DEEP);

  // R4: a retired non-arm op leaves nothing armed
  p_cancel_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && instr_valid && op != OP_ARM) |=> !armed_q);

endmodule

// File: rtl/pdw_stab_counter.sv
module pdw_stab_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             busy,
  input  logic             tick,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (load)                           cnt_q <= load_val;
    else if (busy && tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);

  // R8: once waiting, the count never climbs back up
  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && $past(busy)) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/pdw_flags.sv
module pdw_flags
  import pdw_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sel_we,
  input  logic [1:0]       sel_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic             enter,
  input  logic             wake,
  input  logic             wake_timer,
  output logic             pd_flag,
  output logic             t3_flag,
  output logic [1:0]       sel_q,
  output logic [DIV_W-1:0] div_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'd0;
      div_q <= DIV_W'(1);
    end else if (run && sel_we) begin
      sel_q <= sel_in;
      div_q <= div_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pd_flag <= 1'b0;
    else if (enter) pd_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t3_flag <= 1'b0;
    else if (wake) t3_flag <= wake_timer;
  end

  // R9: the sleep flag is sticky until reset
  p_pflag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_flag) |-> pd_flag);

  // R11: selection is frozen outside run
  p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(sel_q) && $stable(div_q)));

endmodule

// File: rtl/pdw_sequencer.sv
module pdw_sequencer
  import pdw_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int RING_WAIT = 1376,
  parameter int WAIT_MULT = 171
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [1:0]       instr_op,
  input  logic             key_wake,
  input  logic             timer_wake,
  input  logic             sel_we,
  input  logic [1:0]       sel_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic             tick_main,
  input  logic             tick_sub,
  input  logic             tick_ring,
  output logic             run_en,
  output logic             osc_main_en,
  output logic             osc_sub_en,
  output logic             osc_ring_en,
  output logic             pd_flag,
  output logic             t3_flag,
  output logic [1:0]       sel_q
);

  localparam int MAX_RATIO = (1 << DIV_W) - 1;
  localparam int MAX_WAIT  = (RING_WAIT > WAIT_MULT * MAX_RATIO) ? RING_WAIT
                                                                 : WAIT_MULT * MAX_RATIO;
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);

  pstate_t          state_q, state_d;
  logic             enter_light, enter_deep;
  logic             wake_now, wake_timer, from_light;
  logic             cnt_zero, sel_tick, awake;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] load_val;
  src_t             src;

  pdw_entry_decode u_entry (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (state_q == ST_RUN),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .enter_light (enter_light),
    .enter_deep  (enter_deep)
  );

  pdw_flags #(.DIV_W(DIV_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (state_q == ST_RUN),
    .sel_we     (sel_we),
    .sel_in     (sel_in),
    .div_in     (div_in),
    .enter      (enter_light || enter_deep),
    .wake       (wake_now),
    .wake_timer (wake_timer),
    .pd_flag    (pd_flag),
    .t3_flag    (t3_flag),
    .sel_q      (sel_q),
    .div_q      (div_q)
  );

  assign src        = decode_src(sel_q);
  assign from_light = (state_q == ST_LIGHT);
  assign wake_now   = (from_light && (key_wake || timer_wake)) ||
                      ((state_q == ST_DEEP) && key_wake);
  assign wake_timer = from_light && timer_wake && !key_wake;
  assign load_val   = CNT_W'(wait_len(src, from_light, int'(div_q),
                                      RING_WAIT, WAIT_MULT));

  always_comb begin
    case (src)
      SRC_MAIN: sel_tick = tick_main;
      SRC_SUB:  sel_tick = tick_sub;
      default:  sel_tick = tick_ring;
    endcase
  end

  pdw_stab_counter #(.CNT_W(CNT_W)) u_stab (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_now),
    .load_val (load_val),
    .busy     (state_q == ST_WAIT),
    .tick     (sel_tick),
    .cnt_zero (cnt_zero)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (enter_light)     state_d = ST_LIGHT;
        else if (enter_deep) state_d = ST_DEEP;
      end
      ST_LIGHT, ST_DEEP: if (wake_now) state_d = ST_WAIT;
      ST_WAIT:           if (cnt_zero) state_d = ST_RUN;
      default:           state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign awake       = (state_q == ST_RUN) || (state_q == ST_WAIT);
  assign run_en      = (state_q == ST_RUN);
  assign osc_main_en = awake && (src == SRC_MAIN);
  assign osc_ring_en = awake && (src == SRC_RING);
  assign osc_sub_en  = (state_q != ST_DEEP);

  // R2: an armed light-sleep op halts the core at once
  p_enter_light_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_light |=> (!run_en && osc_sub_en && !osc_main_en));

  // R3: deep sleep gates every oscillator
  p_enter_deep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter_deep |=> (!run_en && !osc_sub_en && !osc_ring_en && !osc_main_en));

  // R6: deep sleep holds without a key press
  p_deep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEEP && !key_wake) |=> (state_q == ST_DEEP));

  // R7: release only after an exhausted count
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(cnt_zero && state_q == ST_WAIT));

endmodule

// File: tb/pdw_sequencer_bench.sv
module pdw_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [1:0] instr_op = 2'd0;
  logic key_wake = 1'b0, timer_wake = 1'b0, sel_we = 1'b0;
  logic [1:0] sel_in = 2'd0;
  logic [DIV_W-1:0] div_in = '0;
  logic tick_main = 1'b1, tick_sub = 1'b1, tick_ring = 1'b1;
  logic run_en, osc_main_en, osc_sub_en, osc_ring_en, pd_flag, t3_flag;
  logic [1:0] sel_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdw_sequencer #(.DIV_W(DIV_W)) u_pdw_sequencer (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .key_wake(key_wake), .timer_wake(timer_wake), .sel_we(sel_we),
    .sel_in(sel_in), .div_in(div_in), .tick_main(tick_main),
    .tick_sub(tick_sub), .tick_ring(tick_ring), .run_en(run_en),
    .osc_main_en(osc_main_en), .osc_sub_en(osc_sub_en),
    .osc_ring_en(osc_ring_en), .pd_flag(pd_flag), .t3_flag(t3_flag),
    .sel_q(sel_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input int op);
    instr_valid = 1'b1;
    instr_op = 2'(op);
    step();
    instr_valid = 1'b0;
  endtask

  task automatic set_sel(input int s, input int r);
    sel_we = 1'b1; sel_in = 2'(s); div_in = DIV_W'(r);
    step();
    sel_we = 1'b0;
  endtask

  // Counts edges from the wake edge to the rise of run_en.
  task automatic measure(input bit rewake, input int hold_sub, output int n);
    n = 0;
    while (!run_en && n < 5000) begin
      key_wake = rewake && (n == 2);
      if (n == hold_sub) tick_sub = 1'b1;
      step();
      n++;
    end
    key_wake = 1'b0;
    tick_sub = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, expn;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 run_en", int'(run_en), 1);
    chk("R1 pd_flag", int'(pd_flag), 0);
    chk("R1 t3_flag", int'(t3_flag), 0);
    chk("R1 sel_q", int'(sel_q), 0);
    chk("R1 osc_main", int'(osc_main_en), 1);
    chk("R1 osc_sub", int'(osc_sub_en), 1);
    chk("R1 osc_ring", int'(osc_ring_en), 0);

    // R4: interrupted or unarmed sleep ops have no effect
    issue(1); issue(0); issue(2);
    chk("R4 other op cancels", int'(run_en), 1);
    issue(2);
    chk("R4 unarmed light", int'(run_en), 1);
    issue(1); issue(1); issue(0); issue(3);
    chk("R4 unarmed deep", int'(run_en), 1);
    chk("R9 no entry no flag", int'(pd_flag), 0);

    // Sweep: source x depth x ratio
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < (1 << DIV_W); r++) begin
          bit use_timer;
          use_timer = (d == 0) && r[0];
          set_sel(s, r);
          issue(1);
          if (d == 0 && r[1]) step();          // idle gap keeps arming (R2)
          issue(d == 0 ? 2 : 3);
          chk(d == 0 ? "R2 light halts" : "R3 deep halts", int'(run_en), 0);
          chk("R12 sub enable", int'(osc_sub_en), d == 0 ? 1 : 0);
          chk("R2/R3 main off", int'(osc_main_en), 0);
          chk("R2/R3 ring off", int'(osc_ring_en), 0);
          chk("R9 flag set", int'(pd_flag), 1);
          if (d == 1) begin
            timer_wake = 1'b1;
            repeat (4) step();
            timer_wake = 1'b0;
            chk("R6 timer ignored", int'(run_en), 0);
            sel_we = 1'b1; sel_in = 2'((s + 1) % 4); div_in = DIV_W'(r ^ 1);
            step();
            sel_we = 1'b0;
          end
          if (use_timer) timer_wake = 1'b1; else key_wake = 1'b1;
          step();
          timer_wake = 1'b0; key_wake = 1'b0;
          chk("R11 wait osc main", int'(osc_main_en), s == 0 ? 1 : 0);
          chk("R11 wait osc ring", int'(osc_ring_en), s >= 2 ? 1 : 0);
          expn = (s >= 2 && d == 0) ? 1376 : r * 171;
          measure(1'b1, -1, n);
          chk(use_timer ? "R5 timer wake R7 R8 length" : "R5 key wake R7 R8 length",
              n, expn + 1);
          chk("R10 t3_flag", int'(t3_flag), use_timer ? 1 : 0);
          chk("R11 sel retained", int'(sel_q), s);
          chk("R9 flag sticky", int'(pd_flag), 1);
        end
      end
    end

    // R7: wait counts ticks of the selected source only
    set_sel(1, 1);
    issue(1); issue(2);
    tick_sub = 1'b0;
    key_wake = 1'b1; step(); key_wake = 1'b0;
    measure(1'b0, 40, n);
    chk("R7 sub tick gating", n, 171 + 1 + 40);

    // R10: key and timer together count as a key wake
    issue(1); issue(2);
    key_wake = 1'b1; timer_wake = 1'b1; step();
    key_wake = 1'b0; timer_wake = 1'b0;
    measure(1'b0, -1, n);
    chk("R10 simultaneous wake", int'(t3_flag), 0);

    // R9: reset clears the flag
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R9 reset clears", int'(pd_flag), 0);
    chk("R1 sel after reset", int'(sel_q), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule